// File: doc/BRIEF.md
# Checked CRT Recombination Unit

This block finishes an RSA signature computed with the Chinese remainder theorem. It takes two half-results, one computed modulo p·r and one modulo q·r, where r is a small random prime. It also takes the primes p, q and r and the coefficient iq, the inverse of q modulo p. The block first confirms that both half-results leave the same remainder modulo r. It then brings each half-result down to its own prime, Sp = Spr mod p and Sq = Sqr mod q. The two residues are joined with the Garner formula S = (((Sp − Sq) mod p) · iq mod p) · q + Sq.

Before the signature is released, the block reduces it modulo p and modulo q and compares each residue with the matching half-result reduced to the same prime. Any mismatch, at the modulo-r stage or at this final stage, replaces the signature with the fixed value zero and raises an error flag. A corrupted coefficient or a disturbed combination step therefore never leaves the block as a usable faulty signature.

All arithmetic is bit-serial. One shift-and-subtract reducer and one shift-and-add multiplier are shared by a sequencer. A start pulse latches the operands. A one-cycle done pulse presents the result.

Top module: `crt_combine_chk`

## Requirements
- R1: A start pulse while idle latches all operands and raises busy in the next cycle. busy stays high until the cycle in which done is asserted, and then falls.
- R2: If Spr mod r differs from Sqr mod r, the block finishes with error = 1 and sig = 0.
- R3: When every check passes, sig equals (((Sp − Sq) mod p) · iq mod p) · q + Sq, computed exactly on 64 bits, with error = 0.
- R4: If sig mod p differs from Spr mod p, or sig mod q differs from Sqr mod q, the block finishes with error = 1 and sig = 0. A wrong iq leads to this case.
- R5: The difference (Sp − Sq) mod p is taken as Sp − (Sq mod p), with p added when Sq mod p exceeds Sp, so the result is never negative.
- R6: done is high for exactly one cycle per accepted start. sig and error keep their values until the next done.
- R7: A start pulse while busy is ignored. The running operation completes on the operands latched at its own start.
- R8: After reset, busy, done, error and sig are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| spr | input | 48 | Half-result modulo p·r |
| sqr | input | 48 | Half-result modulo q·r |
| p | input | 32 | First prime |
| q | input | 32 | Second prime |
| r | input | 16 | Small random prime |
| iq | input | 32 | Inverse of q modulo p |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Check failed; valid with done, held after |
| sig | output | 64 | Signature, or zero on error; valid with done, held after |

## Verification
The assertions assume that p, q and r are nonzero whenever an operation starts. The remainder bound in the reducer depends on it. Correct results further assume that p and q are coprime and that iq really inverts q modulo p. The stimulus draws odd p and q with the top bit set, rejects pairs with a common factor, and uses an odd r of at least 2. It builds the half-results by reducing one random 64-bit message modulo p·r and q·r. Error cases are made on purpose by perturbing a half-result or the coefficient.

// File: rtl/crt_pkg.sv
// Shared types for the checked CRT recombination unit.
// Assumes: nothing beyond the state list below.
package crt_pkg;

    // Sequencer steps, in the order they run on the pass path.
    typedef enum logic [3:0] {
        ST_IDLE,  // waiting for start
        ST_RR1,   // spr mod r
        ST_RR2,   // sqr mod r, compare
        ST_SP,    // spr mod p
        ST_SQ,    // sqr mod q
        ST_SQP,   // sq mod p, form difference
        ST_MH,    // difference * iq
        ST_RH,    // product mod p
        ST_MS,    // h * q, add sq
        ST_CP,    // sig mod p, compare
        ST_CQ     // sig mod q, compare
    } crt_state_e;

endpackage

// File: rtl/crt_serial_mod.sv
// Bit-serial shift-and-subtract reducer: result = dividend mod modulus.
// Takes XW cycles after start; done pulses with result valid.
// Assumes: modulus is nonzero at start; start is ignored while busy.
module crt_serial_mod #(
    parameter int XW = 64,
    parameter int MW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW-1:0] dividend,
    input  logic [MW-1:0] modulus,
    output logic          done,
    output logic [MW-1:0] result
);
    localparam int CW = $clog2(XW + 1);

    logic [XW-1:0] x_q;
    logic [MW-1:0] rem_q;
    logic [MW-1:0] mod_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [MW:0]   trial;
    logic [MW-1:0] rem_nxt;

    // Shift one dividend bit into the remainder and subtract if it fits.
    always_comb begin
        trial = {rem_q, x_q[XW-1]};
        if (trial >= {1'b0, mod_q}) begin
            rem_nxt = MW'(trial - {1'b0, mod_q});
        end else begin
            rem_nxt = MW'(trial);
        end
    end

    // Load operands on start, then step once per cycle until all bits are consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            rem_q  <= '0;
            mod_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                x_q    <= dividend;
                mod_q  <= modulus;
                rem_q  <= '0;
                cnt_q  <= CW'(XW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= rem_nxt;
                x_q   <= x_q << 1;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign result = rem_q;

    // R3
    red_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> modulus != '0);

    // R3
    rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> rem_q < mod_q);

endmodule

// File: rtl/crt_serial_mul.sv
// Bit-serial shift-and-add multiplier: product = a * b, full 2*AW width.
// Takes AW cycles after start; done pulses with product valid, product
// then holds until the next start.
// Assumes: start is ignored while busy.
module crt_serial_mul #(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   a,
    input  logic [AW-1:0]   b,
    output logic            done,
    output logic [2*AW-1:0] product
);
    localparam int PWID = 2 * AW;
    localparam int CW   = $clog2(AW + 1);

    logic [PWID-1:0] acc_q;
    logic [PWID-1:0] mc_q;
    logic [AW-1:0]   mp_q;
    logic [CW-1:0]   cnt_q;
    logic            busy_q;

    // Add the shifted multiplicand for each set multiplier bit, LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            mc_q   <= '0;
            mp_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                acc_q  <= '0;
                mc_q   <= PWID'(a);
                mp_q   <= b;
                cnt_q  <= CW'(AW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (mp_q[0]) begin
                    acc_q <= acc_q + mc_q;
                end
                mc_q  <= mc_q << 1;
                mp_q  <= mp_q >> 1;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign product = acc_q;

    // R3
    mul_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mp_q == '0);

endmodule

// File: rtl/crt_combine_chk.sv
// Checked CRT recombination. Latches two half-results (mod p*r, mod q*r),
// the primes and iq on start. Checks agreement modulo r, reduces to the
// primes, combines with the Garner formula, then re-checks the signature
// against both half-results. Any failed check gives error=1 and sig=0.
// Assumes: p, q, r nonzero; p, q coprime and iq = q^-1 mod p for a pass.
module crt_combine_chk
    import crt_pkg::*;
#(
    parameter int PW = 32,
    parameter int RW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PW+RW-1:0] spr,
    input  logic [PW+RW-1:0] sqr,
    input  logic [PW-1:0]    p,
    input  logic [PW-1:0]    q,
    input  logic [RW-1:0]    r,
    input  logic [PW-1:0]    iq,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [2*PW-1:0]  sig
);
    localparam int HW = PW + RW;
    localparam int SW = 2 * PW;

    crt_state_e      state_q;
    logic [HW-1:0]   spr_q, sqr_q;
    logic [PW-1:0]   p_q, q_q, iq_q;
    logic [RW-1:0]   r_q;
    logic [PW-1:0]   rmod_q, sp_q, sq_q, diff_q, h_q;
    logic [SW-1:0]   s_q;
    logic            sub_start_q;

    logic            is_mul;
    logic            red_start, mul_start;
    logic [SW-1:0]   red_x;
    logic [PW-1:0]   red_m;
    logic            red_done;
    logic [PW-1:0]   red_res;
    logic [PW-1:0]   mul_a, mul_b;
    logic            mul_done;
    logic [SW-1:0]   mul_prod;
    logic            step_done;
    logic [PW:0]     diff_wrap;

    // Route latched operands to the shared arithmetic units for each step.
    always_comb begin
        red_x  = '0;
        red_m  = p_q;
        mul_a  = diff_q;
        mul_b  = iq_q;
        is_mul = 1'b0;
        unique case (state_q)
            ST_RR1: begin red_x = SW'(spr_q); red_m = PW'(r_q); end
            ST_RR2: begin red_x = SW'(sqr_q); red_m = PW'(r_q); end
            ST_SP:  begin red_x = SW'(spr_q); red_m = p_q;      end
            ST_SQ:  begin red_x = SW'(sqr_q); red_m = q_q;      end
            ST_SQP: begin red_x = SW'(sq_q);  red_m = p_q;      end
            ST_MH:  begin is_mul = 1'b1; mul_a = diff_q; mul_b = iq_q; end
            ST_RH:  begin red_x = mul_prod;   red_m = p_q;      end
            ST_MS:  begin is_mul = 1'b1; mul_a = h_q; mul_b = q_q; end
            ST_CP:  begin red_x = s_q;        red_m = p_q;      end
            ST_CQ:  begin red_x = s_q;        red_m = q_q;      end
            default: ;
        endcase
    end

    assign red_start = sub_start_q && !is_mul && (state_q != ST_IDLE);
    assign mul_start = sub_start_q && is_mul;
    assign step_done = red_done || mul_done;
    assign busy      = (state_q != ST_IDLE);

    // Wrapped difference Sp - (Sq mod p), adding p when it would go negative.
    assign diff_wrap = {1'b0, sp_q} + {1'b0, p_q} - {1'b0, red_res};

    crt_serial_mod #(.XW(SW), .MW(PW)) u_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (red_start),
        .dividend (red_x),
        .modulus  (red_m),
        .done     (red_done),
        .result   (red_res)
    );

    crt_serial_mul #(.AW(PW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mul_start),
        .a       (mul_a),
        .b       (mul_b),
        .done    (mul_done),
        .product (mul_prod)
    );

    // Sequence the steps, capture intermediate values and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            sub_start_q <= 1'b0;
            spr_q <= '0; sqr_q <= '0; p_q <= '0; q_q <= '0; r_q <= '0; iq_q <= '0;
            rmod_q <= '0; sp_q <= '0; sq_q <= '0; diff_q <= '0; h_q <= '0; s_q <= '0;
            done  <= 1'b0;
            error <= 1'b0;
            sig   <= '0;
        end else begin
            done        <= 1'b0;
            sub_start_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start) begin
                    spr_q <= spr; sqr_q <= sqr; p_q <= p; q_q <= q; r_q <= r; iq_q <= iq;
                    state_q     <= ST_RR1;
                    sub_start_q <= 1'b1;
                end
            end else if (step_done) begin
                sub_start_q <= 1'b1;
                unique case (state_q)
                    ST_RR1: begin rmod_q <= red_res; state_q <= ST_RR2; end
                    ST_RR2: begin
                        if (red_res != rmod_q) begin
                            state_q <= ST_IDLE; sub_start_q <= 1'b0;
                            done <= 1'b1; error <= 1'b1; sig <= '0;
                        end else begin
                            state_q <= ST_SP;
                        end
                    end
                    ST_SP:  begin sp_q <= red_res; state_q <= ST_SQ; end
                    ST_SQ:  begin sq_q <= red_res; state_q <= ST_SQP; end
                    ST_SQP: begin
                        diff_q  <= (sp_q >= red_res) ? (sp_q - red_res) : PW'(diff_wrap);
                        state_q <= ST_MH;
                    end
                    ST_MH:  state_q <= ST_RH;
                    ST_RH:  begin h_q <= red_res; state_q <= ST_MS; end
                    ST_MS:  begin s_q <= mul_prod + SW'(sq_q); state_q <= ST_CP; end
                    ST_CP: begin
                        if (red_res != sp_q) begin
                            state_q <= ST_IDLE; sub_start_q <= 1'b0;
                            done <= 1'b1; error <= 1'b1; sig <= '0;
                        end else begin
                            state_q <= ST_CQ;
                        end
                    end
                    ST_CQ: begin
                        state_q <= ST_IDLE; sub_start_q <= 1'b0;
                        done <= 1'b1;
                        if (red_res != sq_q) begin
                            error <= 1'b1; sig <= '0;
                        end else begin
                            error <= 1'b0; sig <= s_q;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> sig == '0);

    // R1
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(p_q) && $stable(q_q) && $stable(r_q)
                                   && $stable(iq_q) && $stable(spr_q) && $stable(sqr_q)));

    // R2
    rcheck_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RR2 && red_done && red_res != rmod_q) |=> (done && error));

endmodule

// File: tb/tb_crt_combine_chk.sv
`timescale 1ns/1ps
module tb_crt_combine_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] spr = '0, sqr = '0;
    logic [31:0] p = '0, q = '0, iq = '0;
    logic [15:0] r = '0;
    logic        busy, done, error;
    logic [63:0] sig;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    crt_combine_chk dut (
        .clk(clk), .rst_n(rst_n), .start(start), .spr(spr), .sqr(sqr),
        .p(p), .q(q), .r(r), .iq(iq),
        .busy(busy), .done(done), .error(error), .sig(sig)
    );

    always #2.5 clk = ~clk;

    // Global watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic longint unsigned gcd64(input longint unsigned a, input longint unsigned b);
        longint unsigned t;
        while (b != 0) begin t = a % b; a = b; b = t; end
        return a;
    endfunction

    // Inverse of x modulo m by the extended Euclidean algorithm.
    function automatic logic [31:0] modinv(input longint unsigned x, input longint unsigned m);
        longint old_r = longint'(x % m), rr = longint'(m);
        longint old_s = 1, s = 0, qt, tmp;
        while (rr != 0) begin
            qt = old_r / rr;
            tmp = old_r - qt * rr; old_r = rr; rr = tmp;
            tmp = old_s - qt * s;  old_s = s;  s = tmp;
        end
        if (old_s < 0) old_s = old_s + longint'(m);
        return 32'(old_s);
    endfunction

    // Reference result from the requirements (R2..R5).
    function automatic void model(input logic [47:0] a_spr, input logic [47:0] a_sqr,
                                  input logic [31:0] a_p, input logic [31:0] a_q,
                                  input logic [15:0] a_r, input logic [31:0] a_iq,
                                  output bit e, output logic [63:0] s);
        logic [63:0] vsp, vsq, vsqp, d, h;
        e = 0; s = '0;
        if ((64'(a_spr) % 64'(a_r)) != (64'(a_sqr) % 64'(a_r))) begin e = 1; return; end
        vsp  = 64'(a_spr) % 64'(a_p);
        vsq  = 64'(a_sqr) % 64'(a_q);
        vsqp = vsq % 64'(a_p);
        d    = (vsp >= vsqp) ? vsp - vsqp : vsp + 64'(a_p) - vsqp;
        h    = (d * 64'(a_iq)) % 64'(a_p);
        s    = h * 64'(a_q) + vsq;
        if ((s % 64'(a_p)) != vsp || (s % 64'(a_q)) != vsq) begin e = 1; s = '0; end
    endfunction

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
    endtask

    // Run one operation and compare against the model.
    task automatic run(input string req, input bit chk_hold);
        bit          e_exp;
        logic [63:0] s_exp, s_seen;
        model(spr, sqr, p, q, r, iq, e_exp, s_exp);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", 64'(busy), 64'd1);
        wait_done();
        chk(done == 1'b1, "R6 done seen", 64'(done), 64'd1);
        chk(error == e_exp, {req, " error"}, 64'(error), 64'(e_exp));
        chk(sig == s_exp, {req, " sig"}, sig, s_exp);
        chk(busy == 1'b0, "R1 idle at done", 64'(busy), 64'd0);
        if (chk_hold) begin
            s_seen = sig;
            @(negedge clk);
            chk(done == 1'b0, "R6 done one cycle", 64'(done), 64'd0);
            chk(sig == s_seen, "R6 sig held", sig, s_seen);
        end
    endtask

    // Build a consistent operand set from a message m.
    task automatic make_ops(input logic [31:0] ap, input logic [31:0] aq,
                            input logic [15:0] ar, input logic [63:0] m);
        p = ap; q = aq; r = ar;
        spr = 48'(m % (64'(ap) * 64'(ar)));
        sqr = 48'(m % (64'(aq) * 64'(ar)));
        iq  = modinv(64'(aq), 64'(ap));
    endtask

    task automatic rand_pq(output logic [31:0] ap, output logic [31:0] aq);
        do begin
            ap = $urandom | 32'h8000_0001;
            aq = $urandom | 32'h8000_0001;
        end while (ap == aq || gcd64(64'(ap), 64'(aq)) != 1);
    endtask

    initial begin
        int unsigned seed_ret;
        logic [31:0] tp, tq;
        logic [15:0] tr;
        logic [63:0] tm;
        bit          e_x;
        logic [63:0] s_x;
        seed_ret = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(busy == 0, "R8 busy", 64'(busy), 0);
        chk(done == 0, "R8 done", 64'(done), 0);
        chk(error == 0, "R8 error", 64'(error), 0);
        chk(sig == 0, "R8 sig", sig, 0);

        // R3 directed: small coprime values
        make_ops(32'd1000003, 32'd999983, 16'd65521, 64'd123456789012345);
        run("R3 directed", 1'b1);

        // R5 wrap: p > q and m = p gives Sp = 0 < Sq mod p
        tp = 32'hFFFF_FFFB; tq = 32'h8000_000B;
        make_ops(tp, tq, 16'd40009, 64'(tp));
        run("R5 wrap", 1'b1);

        // R2 mismatch modulo r
        rand_pq(tp, tq);
        make_ops(tp, tq, 16'd257, {$urandom, $urandom});
        spr = spr ^ 48'h1;
        run("R2 r mismatch", 1'b1);
        chk(error == 1'b1, "R2 error flagged", 64'(error), 64'd1);

        // R4 wrong coefficient; message chosen so Sp differs from Sq mod p
        rand_pq(tp, tq);
        make_ops(tp, tq, 16'd1031, 64'(tq) + 64'd5);
        iq = iq + 32'd1;
        model(spr, sqr, p, q, r, iq, e_x, s_x);
        chk(e_x == 1'b1, "R4 case is an error case", 64'(e_x), 64'd1);
        run("R4 bad iq", 1'b1);

        // R7 start while busy is ignored
        rand_pq(tp, tq);
        make_ops(tp, tq, 16'd3001, {$urandom, $urandom});
        model(spr, sqr, p, q, r, iq, e_x, s_x);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        p = 32'd7; q = 32'd5; r = 16'd3; spr = 48'd1; sqr = 48'd2; iq = 32'd3;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R7 still busy", 64'(busy), 64'd1);
        wait_done();
        chk(error == e_x, "R7 error of first op", 64'(error), 64'(e_x));
        chk(sig == s_x, "R7 sig of first op", sig, s_x);
        @(negedge clk);

        // R3 random, with occasional R2/R4 perturbations
        for (int i = 0; i < 60; i++) begin
            rand_pq(tp, tq);
            tr = 16'($urandom) | 16'h0003;
            tm = {$urandom, $urandom};
            make_ops(tp, tq, tr, tm);
            if (i % 7 == 3) begin
                sqr = sqr + 48'd1;
                run("R2 random mismatch", 1'b0);
            end else if (i % 7 == 5) begin
                iq = iq ^ 32'h0000_0100;
                run("R4 random bad iq", 1'b0);
            end else begin
                run("R3 random", (i % 10) == 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule